// File: doc/BRIEF.md
# Serial NAND Page Read Sequencer

This block fetches one page from a serial NAND flash on behalf of a host. A single `start` pulse triggers three kinds of bus frame in a fixed order, each framed by its own chip-select assertion. The first frame tells the flash to copy the addressed page into its internal cache. The next frames poll the flash status until the flash reports ready, or until a poll budget runs out. The last frame streams the cache contents back to the host.

Every command, address and status poll travels on a single lane. Only the data phase of the cache read uses the width picked by two mode-select pins: one, four or eight lanes. Bytes from the cache leave the block on a plain valid/byte stream. The block reports failure on either of two flags. One marks an uncorrectable ECC result found in the status register after the page load. The other marks a flash that never became ready.

The bus runs in SPI mode 0. The serial clock is half the system clock. It idles low and rises in the second system cycle of each bit. Outgoing data changes only while the serial clock is low. Incoming data is sampled at the end of the high half.

Top module: `snand_page_reader`

## Requirements
- R1: With `mode_sel2` high the read runs in single-lane mode whatever `mode_sel1` is. The cache-read opcode is 0x0B and each data byte arrives MSB first on `dq_in[1]`, one bit per serial clock.
- R2: With `mode_sel2` low, `mode_sel1` = 0 selects eight-lane mode: opcode 0x8B, one byte per serial clock on `dq_in[7:0]`, bit 7 on lane 7. `mode_sel1` = 1 selects four-lane mode: opcode 0x6B, two clocks per byte on `dq_in[3:0]`, high nibble first.
- R3: The first frame of a read is 32 serial clocks long. It carries 0x13 followed by the 24-bit `row_addr`, MSB first on `dq_out[0]`.
- R4: Each status poll is a frame of 24 serial clocks. It carries 0x0F and 0xC0 on `dq_out[0]`, then receives the status byte MSB first on `dq_in[1]`. Chip select goes high between any two frames. A status with bit 0 set causes another poll.
- R5: If `MAX_POLLS` polls in a row all return bit 0 set, the read ends with `done` and `fail_timeout`. No cache-read frame is sent and no byte is streamed.
- R6: A ready status (bit 0 clear) with bit 5 set ends the read with `done` and `fail_ecc`, and streams no bytes. Bit 5 seen while bit 0 is set does not end the read. Bit 4 alone (a corrected error) does not cause a failure.
- R7: A successful read ends with a cache-read frame: opcode, 16-bit `col_addr` and 8 dummy clocks on one lane, then the data. The block streams exactly `SMALL_PAGE_BYTES` bytes, or `LARGE_PAGE_BYTES` when `page_large` was high at start, on `rd_valid`/`rd_byte`. It then pulses `done` with both fail flags low.
- R8: `sclk` is low whenever `cs_n` is high. `dq_out` does not change while `sclk` is high.
- R9: In and right after reset: `cs_n` = 1, `sclk` = 0, `busy` = 0, `done` = 0 and `rd_valid` = 0.
- R10: A `start` while `busy` is high is ignored. `done` is a one-cycle pulse. The fail flags hold their value after `done` until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page read (accepted when idle) |
| row_addr | input | 24 | Page (row) address for the load command |
| col_addr | input | 16 | Starting column in the cache |
| page_large | input | 1 | 1 selects the large page size |
| mode_sel1 | input | 1 | Width select: 0 eight lanes, 1 four lanes (used when mode_sel2 is 0) |
| mode_sel2 | input | 1 | 1 forces single-lane mode |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| dq_out | output | 8 | Data lanes driven to the flash |
| dq_oe | output | 8 | Output enable per lane |
| dq_in | input | 8 | Data lanes from the flash |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse at the end of a read |
| fail_ecc | output | 1 | Read ended on an uncorrectable ECC status |
| fail_timeout | output | 1 | Read ended because the flash stayed busy |
| rd_valid | output | 1 | `rd_byte` holds a page byte this cycle |
| rd_byte | output | 8 | Page data byte |

## Verification
Two status bits meet in one status byte: the busy flag and the uncorrectable-ECC flag. The bench's flash model answers every busy poll with 0x21, so both bits are set together. A read must treat that byte as busy and keep polling, never as an ECC failure. The model then returns the vector's final status, and the outcome is judged by counting frames, the fail flags and the streamed bytes.

The second pairing is a new `start` arriving while a read is running. The bench raises it in the middle of a read with a different row and mode, then checks that the frames sent and the bytes streamed still match the first request alone.

// File: rtl/snand_pkg.sv
package snand_pkg;

   typedef enum logic [1:0] {
      LANES_X1 = 2'd0,
      LANES_X4 = 2'd1,
      LANES_X8 = 2'd2
   } lane_mode_e;

   localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
   localparam logic [7:0] OP_GET_FEAT  = 8'h0F;
   localparam logic [7:0] FEAT_STATUS  = 8'hC0;
   localparam logic [7:0] OP_CACHE_X1  = 8'h0B;
   localparam logic [7:0] OP_CACHE_X4  = 8'h6B;
   localparam logic [7:0] OP_CACHE_X8  = 8'h8B;

   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_UNCORR_BIT = 5;

   typedef struct packed {
      logic [31:0] tx_word;   // MSB first on lane 0
      logic [5:0]  tx_bits;   // 1..32
      logic [3:0]  dummy;     // dummy serial clocks after tx
      logic        rx_en;     // data phase follows
      lane_mode_e  lanes;     // width of the data phase
   } frame_req_t;

endpackage

// File: rtl/snand_mode_decode.sv
module snand_mode_decode
   import snand_pkg::*;
(
   input  logic       sel1,
   input  logic       sel2,
   output lane_mode_e lanes,
   output logic [7:0] rd_opcode
);

   always_comb begin
      if (sel2) begin
         lanes     = LANES_X1;
         rd_opcode = OP_CACHE_X1;
      end else if (sel1) begin
         lanes     = LANES_X4;
         rd_opcode = OP_CACHE_X4;
      end else begin
         lanes     = LANES_X8;
         rd_opcode = OP_CACHE_X8;
      end
   end

endmodule

// File: rtl/snand_frame_engine.sv
module snand_frame_engine
   import snand_pkg::*;
#(
   parameter int CNT_W      = 13,
   parameter int GAP_CYCLES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  frame_req_t       req,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [7:0]       dq_in,
   output logic             frame_done,
   output logic             rx_valid,
   output logic [7:0]       rx_byte,
   output logic             sclk,
   output logic             cs_n,
   output logic [7:0]       dq_out,
   output logic [7:0]       dq_oe
);

   localparam logic [5:0] GAP_LAST = 6'(GAP_CYCLES - 1);

   if (GAP_CYCLES < 1 || GAP_CYCLES > 32) begin : g_bad_gap
      $error("GAP_CYCLES must lie in 1..32");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   typedef enum logic [2:0] {E_IDLE, E_TX, E_DUMMY, E_RX, E_GAP} eng_st_e;

   eng_st_e          st;
   logic             half;
   logic [31:0]      sh;
   logic [5:0]       ccnt;
   logic [2:0]       beat;
   logic [CNT_W-1:0] bleft;
   logic [7:0]       rsh;
   lane_mode_e       lm;
   logic [3:0]       dmy;
   logic             rxen;
   logic [2:0]       last_beat;
   logic [7:0]       rx_next;

   always_comb begin
      unique case (lm)
         LANES_X4: begin
            last_beat = 3'd1;
            rx_next   = {rsh[3:0], dq_in[3:0]};
         end
         LANES_X8: begin
            last_beat = 3'd0;
            rx_next   = dq_in;
         end
         default: begin
            last_beat = 3'd7;
            rx_next   = {rsh[6:0], dq_in[1]};
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= E_IDLE;
         half       <= 1'b0;
         sh         <= '0;
         ccnt       <= '0;
         beat       <= '0;
         bleft      <= '0;
         rsh        <= '0;
         lm         <= LANES_X1;
         dmy        <= '0;
         rxen       <= 1'b0;
         frame_done <= 1'b0;
         rx_valid   <= 1'b0;
         rx_byte    <= '0;
      end else begin
         frame_done <= 1'b0;
         rx_valid   <= 1'b0;
         unique case (st)
            E_IDLE: begin
               if (go) begin
                  st    <= E_TX;
                  sh    <= req.tx_word;
                  ccnt  <= req.tx_bits - 6'd1;
                  half  <= 1'b0;
                  lm    <= req.lanes;
                  dmy   <= req.dummy;
                  rxen  <= req.rx_en;
                  bleft <= rx_count;
                  beat  <= '0;
               end
            end
            E_TX: begin
               half <= ~half;
               if (half) begin
                  sh   <= {sh[30:0], 1'b0};
                  ccnt <= ccnt - 6'd1;
                  if (ccnt == 6'd0) begin
                     if (dmy != 4'd0) begin
                        st   <= E_DUMMY;
                        ccnt <= {2'b00, dmy} - 6'd1;
                     end else if (rxen) begin
                        st <= E_RX;
                     end else begin
                        st   <= E_GAP;
                        ccnt <= GAP_LAST;
                     end
                  end
               end
            end
            E_DUMMY: begin
               half <= ~half;
               if (half) begin
                  ccnt <= ccnt - 6'd1;
                  if (ccnt == 6'd0) begin
                     if (rxen) begin
                        st <= E_RX;
                     end else begin
                        st   <= E_GAP;
                        ccnt <= GAP_LAST;
                     end
                  end
               end
            end
            E_RX: begin
               half <= ~half;
               if (half) begin
                  rsh <= rx_next;
                  if (beat == last_beat) begin
                     beat     <= '0;
                     rx_valid <= 1'b1;
                     rx_byte  <= rx_next;
                     bleft    <= bleft - 1'b1;
                     if (bleft == CNT_W'(1)) begin
                        st   <= E_GAP;
                        ccnt <= GAP_LAST;
                     end
                  end else begin
                     beat <= beat + 3'd1;
                  end
               end
            end
            default: begin
               ccnt <= ccnt - 6'd1;
               if (ccnt == 6'd0) begin
                  st         <= E_IDLE;
                  frame_done <= 1'b1;
               end
            end
         endcase
      end
   end

   assign cs_n = (st == E_IDLE) || (st == E_GAP);
   assign sclk = half && !cs_n;

   for (genvar ln = 0; ln < 8; ln++) begin : g_lane
      if (ln == 0) begin : g_cmd
         assign dq_out[ln] = (st == E_TX) ? sh[31] : 1'b0;
         assign dq_oe[ln]  = (st == E_TX);
      end else begin : g_rx_only
         assign dq_out[ln] = 1'b0;
         assign dq_oe[ln]  = 1'b0;
      end
   end

endmodule

// File: rtl/snand_page_seq.sv
module snand_page_seq
   import snand_pkg::*;
#(
   parameter int SMALL_PAGE_BYTES = 2048,
   parameter int LARGE_PAGE_BYTES = 4096,
   parameter int MAX_POLLS        = 64,
   parameter int DUMMY_CLKS       = 8,
   parameter int CNT_W            = 13,
   parameter int POLL_W           = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [23:0]      row_addr,
   input  logic [15:0]      col_addr,
   input  logic             page_large,
   input  lane_mode_e       dec_lanes,
   input  logic [7:0]       dec_opcode,
   input  logic             frame_done,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   output logic             go,
   output frame_req_t       req,
   output logic [CNT_W-1:0] rx_count,
   output logic             busy,
   output logic             done,
   output logic             fail_ecc,
   output logic             fail_timeout,
   output logic             out_valid,
   output logic [7:0]       out_byte
);

   localparam logic [CNT_W-1:0]  SMALL_CNT = CNT_W'(SMALL_PAGE_BYTES);
   localparam logic [CNT_W-1:0]  LARGE_CNT = CNT_W'(LARGE_PAGE_BYTES);
   localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);
   localparam logic [3:0]        DUMMY_N   = 4'(DUMMY_CLKS);

   typedef enum logic [1:0] {S_IDLE, S_LOAD, S_POLL, S_READ} seq_st_e;

   seq_st_e          st;
   logic [POLL_W-1:0] polls;
   logic [7:0]       stat;
   logic [15:0]      col_q;
   logic [7:0]       op_q;
   lane_mode_e       lanes_q;
   logic             large_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= S_IDLE;
         polls        <= '0;
         stat         <= '0;
         col_q        <= '0;
         op_q         <= '0;
         lanes_q      <= LANES_X1;
         large_q      <= 1'b0;
         go           <= 1'b0;
         req          <= '0;
         rx_count     <= '0;
         done         <= 1'b0;
         fail_ecc     <= 1'b0;
         fail_timeout <= 1'b0;
         out_valid    <= 1'b0;
         out_byte     <= '0;
      end else begin
         go        <= 1'b0;
         done      <= 1'b0;
         out_valid <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  st           <= S_LOAD;
                  col_q        <= col_addr;
                  op_q         <= dec_opcode;
                  lanes_q      <= dec_lanes;
                  large_q      <= page_large;
                  fail_ecc     <= 1'b0;
                  fail_timeout <= 1'b0;
                  go           <= 1'b1;
                  req          <= '{tx_word: {OP_PAGE_LOAD, row_addr}, tx_bits: 6'd32,
                                    dummy: 4'd0, rx_en: 1'b0, lanes: LANES_X1};
                  rx_count     <= '0;
               end
            end
            S_LOAD: begin
               if (frame_done) begin
                  st       <= S_POLL;
                  polls    <= '0;
                  go       <= 1'b1;
                  req      <= '{tx_word: {OP_GET_FEAT, FEAT_STATUS, 16'h0000}, tx_bits: 6'd16,
                                dummy: 4'd0, rx_en: 1'b1, lanes: LANES_X1};
                  rx_count <= CNT_W'(1);
               end
            end
            S_POLL: begin
               if (rx_valid) begin
                  stat <= rx_byte;
               end
               if (frame_done) begin
                  if (stat[STAT_BUSY_BIT]) begin
                     if (polls == POLL_LAST) begin
                        st           <= S_IDLE;
                        done         <= 1'b1;
                        fail_timeout <= 1'b1;
                     end else begin
                        polls <= polls + 1'b1;
                        go    <= 1'b1;
                     end
                  end else if (stat[STAT_UNCORR_BIT]) begin
                     st       <= S_IDLE;
                     done     <= 1'b1;
                     fail_ecc <= 1'b1;
                  end else begin
                     st       <= S_READ;
                     go       <= 1'b1;
                     req      <= '{tx_word: {op_q, col_q, 8'h00}, tx_bits: 6'd24,
                                   dummy: DUMMY_N, rx_en: 1'b1, lanes: lanes_q};
                     rx_count <= large_q ? LARGE_CNT : SMALL_CNT;
                  end
               end
            end
            default: begin
               out_valid <= rx_valid;
               out_byte  <= rx_byte;
               if (frame_done) begin
                  st   <= S_IDLE;
                  done <= 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (st != S_IDLE);

endmodule

// File: rtl/snand_page_reader.sv
module snand_page_reader
   import snand_pkg::*;
#(
   parameter int SMALL_PAGE_BYTES = 2048,
   parameter int LARGE_PAGE_BYTES = 4096,
   parameter int MAX_POLLS        = 64,
   parameter int DUMMY_CLKS       = 8,
   parameter int GAP_CYCLES       = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic [23:0] row_addr,
   input  logic [15:0] col_addr,
   input  logic        page_large,
   input  logic        mode_sel1,
   input  logic        mode_sel2,
   output logic        sclk,
   output logic        cs_n,
   output logic [7:0]  dq_out,
   output logic [7:0]  dq_oe,
   input  logic [7:0]  dq_in,
   output logic        busy,
   output logic        done,
   output logic        fail_ecc,
   output logic        fail_timeout,
   output logic        rd_valid,
   output logic [7:0]  rd_byte
);

   localparam int CNT_W  = $clog2(LARGE_PAGE_BYTES + 1);
   localparam int POLL_W = $clog2(MAX_POLLS + 1);

   if (SMALL_PAGE_BYTES < 1 || LARGE_PAGE_BYTES < SMALL_PAGE_BYTES) begin : g_bad_page
      $error("page sizes must satisfy 1 <= SMALL <= LARGE");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("MAX_POLLS must be at least 1");
   end
   if (DUMMY_CLKS < 0 || DUMMY_CLKS > 15) begin : g_bad_dummy
      $error("DUMMY_CLKS must lie in 0..15");
   end

   lane_mode_e       dec_lanes;
   logic [7:0]       dec_opcode;
   logic             go;
   frame_req_t       req;
   logic [CNT_W-1:0] rx_count;
   logic             frame_done;
   logic             rx_valid;
   logic [7:0]       rx_byte;

   snand_mode_decode i_decode (
      .sel1      (mode_sel1),
      .sel2      (mode_sel2),
      .lanes     (dec_lanes),
      .rd_opcode (dec_opcode)
   );

   snand_page_seq #(
      .SMALL_PAGE_BYTES (SMALL_PAGE_BYTES),
      .LARGE_PAGE_BYTES (LARGE_PAGE_BYTES),
      .MAX_POLLS        (MAX_POLLS),
      .DUMMY_CLKS       (DUMMY_CLKS),
      .CNT_W            (CNT_W),
      .POLL_W           (POLL_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .row_addr     (row_addr),
      .col_addr     (col_addr),
      .page_large   (page_large),
      .dec_lanes    (dec_lanes),
      .dec_opcode   (dec_opcode),
      .frame_done   (frame_done),
      .rx_valid     (rx_valid),
      .rx_byte      (rx_byte),
      .go           (go),
      .req          (req),
      .rx_count     (rx_count),
      .busy         (busy),
      .done         (done),
      .fail_ecc     (fail_ecc),
      .fail_timeout (fail_timeout),
      .out_valid    (rd_valid),
      .out_byte     (rd_byte)
   );

   snand_frame_engine #(
      .CNT_W      (CNT_W),
      .GAP_CYCLES (GAP_CYCLES)
   ) i_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .req        (req),
      .rx_count   (rx_count),
      .dq_in      (dq_in),
      .frame_done (frame_done),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .dq_out     (dq_out),
      .dq_oe      (dq_oe)
   );

endmodule

// File: rtl/snand_page_reader_chk.sv
module snand_page_reader_chk #(
   parameter int SMALL_PAGE_BYTES = 2048,
   parameter int LARGE_PAGE_BYTES = 4096,
   parameter int MAX_POLLS        = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       page_large,
   input logic       sclk,
   input logic       cs_n,
   input logic [7:0] dq_out,
   input logic       busy,
   input logic       done,
   input logic       fail_ecc,
   input logic       fail_timeout,
   input logic       rd_valid
);

   int   byte_cnt;
   int   frame_cnt;
   logic large_q;
   logic cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_cnt  <= 0;
         frame_cnt <= 0;
         large_q   <= 1'b0;
         cs_q      <= 1'b1;
      end else begin
         cs_q <= cs_n;
         if (start && !busy) begin
            byte_cnt  <= 0;
            frame_cnt <= 0;
            large_q   <= page_large;
         end else begin
            if (rd_valid) byte_cnt <= byte_cnt + 1;
            if (cs_q && !cs_n) frame_cnt <= frame_cnt + 1;
         end
      end
   end

   a_r8_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r8_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk) |-> $stable(dq_out));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(fail_ecc && fail_timeout));

   a_r5_no_bytes_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (fail_ecc || fail_timeout)) |-> (byte_cnt == 0));

   a_r7_page_length: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail_ecc && !fail_timeout) |->
         (byte_cnt == (large_q ? LARGE_PAGE_BYTES : SMALL_PAGE_BYTES)));

   a_r7_valid_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

   a_r4_frame_budget: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (frame_cnt <= MAX_POLLS + 2));

endmodule

bind snand_page_reader snand_page_reader_chk #(
   .SMALL_PAGE_BYTES (SMALL_PAGE_BYTES),
   .LARGE_PAGE_BYTES (LARGE_PAGE_BYTES),
   .MAX_POLLS        (MAX_POLLS)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .page_large   (page_large),
   .sclk         (sclk),
   .cs_n         (cs_n),
   .dq_out       (dq_out),
   .busy         (busy),
   .done         (done),
   .fail_ecc     (fail_ecc),
   .fail_timeout (fail_timeout),
   .rd_valid     (rd_valid)
);

// File: tb/test_snand_page_reader.sv
module test_snand_page_reader;

   localparam int SMALL = 16;
   localparam int LARGE = 32;
   localparam int POLLS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] row_addr = '0;
   logic [15:0] col_addr = '0;
   logic        page_large = 1'b0;
   logic        mode_sel1 = 1'b0;
   logic        mode_sel2 = 1'b0;
   logic        sclk, cs_n, busy, done, fail_ecc, fail_timeout, rd_valid;
   logic [7:0]  dq_out, dq_oe, rd_byte;
   logic [7:0]  dq_in;

   always #5 clk = ~clk;

   snand_page_reader #(
      .SMALL_PAGE_BYTES (SMALL),
      .LARGE_PAGE_BYTES (LARGE),
      .MAX_POLLS        (POLLS)
   ) i_snand_page_reader (
      .clk (clk), .rst_n (rst_n), .start (start), .row_addr (row_addr),
      .col_addr (col_addr), .page_large (page_large), .mode_sel1 (mode_sel1),
      .mode_sel2 (mode_sel2), .sclk (sclk), .cs_n (cs_n), .dq_out (dq_out),
      .dq_oe (dq_oe), .dq_in (dq_in), .busy (busy), .done (done),
      .fail_ecc (fail_ecc), .fail_timeout (fail_timeout),
      .rd_valid (rd_valid), .rd_byte (rd_byte)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] page_byte(input logic [15:0] col, input int k);
      return (col[7:0] ^ 8'hA5) + 8'(k * 3);
   endfunction

   // ---------------- flash model ----------------
   int          total_frames = 0;
   int          total_polls  = 0;
   logic [31:0] f_sh  [32];
   int          f_clk [32];
   int          poll_base = 0;
   int          busy_n    = 0;
   logic [7:0]  ready_stat = 8'h00;

   initial begin
      dq_in = '0;
      forever begin
         logic [31:0] sh;
         int          nclk;
         logic [7:0]  op;
         sh = '0; nclk = 0; op = '0;
         @(negedge cs_n);
         forever begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) break;
            if (nclk < 32) sh = {sh[30:0], dq_out[0]};
            nclk++;
            if (nclk == 8) op = sh[7:0];
            @(negedge sclk or posedge cs_n);
            #1;
            if (cs_n) break;
            if (op == 8'h0F && nclk >= 16 && nclk < 24) begin
               logic [7:0] st;
               st = ((total_polls - poll_base) < busy_n) ? 8'h21 : ready_stat;
               dq_in[1] = st[23 - nclk];
            end else if (nclk >= 32) begin
               int k;
               logic [7:0] b;
               k = nclk - 32;
               if (op == 8'h0B) begin
                  b = page_byte(sh[23:8], k / 8);
                  dq_in[1] = b[7 - (k % 8)];
               end else if (op == 8'h6B) begin
                  b = page_byte(sh[23:8], k / 2);
                  dq_in[3:0] = (k % 2 == 0) ? b[7:4] : b[3:0];
               end else if (op == 8'h8B) begin
                  dq_in = page_byte(sh[23:8], k);
               end
            end
         end
         f_sh[total_frames % 32]  = sh;
         f_clk[total_frames % 32] = nclk;
         if (op == 8'h0F) total_polls++;
         total_frames++;
         dq_in = '0;
      end
   end

   // ---------------- byte collector ----------------
   int         total_bytes = 0;
   logic [7:0] rbuf [64];
   always @(negedge clk) begin
      if (rd_valid) begin
         rbuf[total_bytes % 64] = rd_byte;
         total_bytes++;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   int frame_base;
   int byte_base;

   task automatic begin_read(input logic mb, input logic ma, input logic pl, input int bn,
                             input logic [7:0] st, input logic [23:0] row, input logic [15:0] col);
      @(negedge clk);
      busy_n     = bn;
      ready_stat = st;
      poll_base  = total_polls;
      frame_base = total_frames;
      byte_base  = total_bytes;
      mode_sel2  = mb;
      mode_sel1  = ma;
      page_large = pl;
      row_addr   = row;
      col_addr   = col;
      start      = 1'b1;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      int n;
      ok = 1'b0;
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
      end
      ok = done;
   endtask

   // stimulus / expected table:
   // {mode_sel2, mode_sel1, page_large, busy polls[2:0], ready status, row, col, exp opcode, exp result}
   // exp result: 0 data streamed, 1 ECC failure, 2 timeout
   localparam int NV = 8;
   localparam logic [63:0] VEC [NV] = '{
      {1'b1, 1'b0, 1'b0, 3'd0, 8'h00, 24'h000040, 16'h0000, 8'h0B, 2'd0},
      {1'b1, 1'b1, 1'b1, 3'd1, 8'h00, 24'h012345, 16'h0010, 8'h0B, 2'd0},
      {1'b0, 1'b0, 1'b0, 3'd2, 8'h10, 24'hABCDEF, 16'h0800, 8'h8B, 2'd0},
      {1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 24'h000001, 16'h0123, 8'h6B, 2'd0},
      {1'b0, 1'b1, 1'b0, 3'd1, 8'h20, 24'h0007FF, 16'h0000, 8'h6B, 2'd1},
      {1'b0, 1'b0, 1'b0, 3'd4, 8'h00, 24'h000003, 16'h0000, 8'h8B, 2'd2},
      {1'b1, 1'b0, 1'b0, 3'd3, 8'h30, 24'h5A5A5A, 16'h0002, 8'h0B, 2'd1},
      {1'b0, 1'b0, 1'b1, 3'd3, 8'h00, 24'hFFFFFF, 16'hFFF0, 8'h8B, 2'd0}
   };

   initial begin
      bit ok;
      // R9 reset state
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0, "R9 reset bus idle", {cs_n, sclk}, 2'b10);
      chk(busy == 1'b0 && done == 1'b0 && rd_valid == 1'b0, "R9 reset status",
          {busy, done, rd_valid}, 3'b000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R9 after reset",
          {cs_n, sclk, busy}, 3'b100);

      for (int v = 0; v < NV; v++) begin
         logic        mb, ma, pl;
         int          bn, page, lanes, polls, nfr, exp_bytes, bad, nb;
         logic [7:0]  st, op;
         logic [23:0] row;
         logic [15:0] col;
         logic [1:0]  res;
         {mb, ma, pl} = VEC[v][63:61];
         bn  = int'(VEC[v][60:58]);
         st  = VEC[v][57:50];
         row = VEC[v][49:26];
         col = VEC[v][25:10];
         op  = VEC[v][9:2];
         res = VEC[v][1:0];
         page  = pl ? LARGE : SMALL;
         lanes = (op == 8'h0B) ? 1 : (op == 8'h6B) ? 4 : 8;
         polls = (res == 2'd2) ? POLLS : bn + 1;
         nfr   = 1 + polls + ((res == 2'd0) ? 1 : 0);
         exp_bytes = (res == 2'd0) ? page : 0;

         begin_read(mb, ma, pl, bn, st, row, col);
         wait_done(ok);
         chk(ok, "R7 done reached", ok, 1);
         chk({fail_timeout, fail_ecc} == res, "R5 R6 outcome flags",
             {fail_timeout, fail_ecc}, res);
         repeat (2) @(negedge clk);
         chk(total_frames - frame_base == nfr, "R4 frame count", total_frames - frame_base, nfr);
         chk(f_sh[frame_base % 32] == {8'h13, row} && f_clk[frame_base % 32] == 32,
             "R3 page load frame", f_sh[frame_base % 32], {8'h13, row});
         bad = 0;
         for (int p = 1; p <= polls; p++) begin
            int ix;
            ix = (frame_base + p) % 32;
            if (f_sh[ix][23:8] != 16'h0FC0 || f_clk[ix] != 24) bad++;
         end
         chk(bad == 0, "R4 status poll frames", bad, 0);
         nb = total_bytes - byte_base;
         chk(nb == exp_bytes, "R7 R5 R6 byte count", nb, exp_bytes);
         if (res == 2'd0) begin
            int ix;
            ix = (frame_base + nfr - 1) % 32;
            chk(f_sh[ix][31:24] == op, "R1 R2 cache read opcode", f_sh[ix][31:24], op);
            chk(f_sh[ix][23:8] == col && f_clk[ix] == 32 + page * 8 / lanes,
                "R7 cache read frame", f_clk[ix], 32 + page * 8 / lanes);
            bad = 0;
            for (int k = 0; k < page; k++)
               if (rbuf[(byte_base + k) % 64] != page_byte(col, k)) bad++;
            chk(bad == 0, "R1 R2 page data", bad, 0);
         end
      end

      // R10: start while busy is ignored
      begin_read(1'b0, 1'b0, 1'b0, 1, 8'h00, 24'h00C0DE, 16'h0004);
      repeat (40) @(negedge clk);
      row_addr = 24'h777777; mode_sel2 = 1'b1; page_large = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      repeat (2) @(negedge clk);
      chk(total_frames - frame_base == 4, "R10 busy start frames", total_frames - frame_base, 4);
      chk(f_sh[frame_base % 32] == {8'h13, 24'h00C0DE}, "R10 busy start row",
          f_sh[frame_base % 32], {8'h13, 24'h00C0DE});
      chk(total_bytes - byte_base == SMALL, "R10 busy start bytes", total_bytes - byte_base, SMALL);

      // R10: done pulse width and held flags
      begin_read(1'b0, 1'b1, 1'b0, 0, 8'h20, 24'h000010, 16'h0000);
      wait_done(ok);
      @(negedge clk);
      chk(done == 1'b0, "R10 done one cycle", done, 0);
      repeat (10) @(negedge clk);
      chk(fail_ecc == 1'b1, "R10 flag held", fail_ecc, 1);
      begin_read(1'b1, 1'b0, 1'b0, 0, 8'h00, 24'h000011, 16'h0000);
      chk(fail_ecc == 1'b0 && busy == 1'b1, "R10 flag cleared by start", {fail_ecc, busy}, 2'b01);
      wait_done(ok);
      chk(ok && !fail_ecc && !fail_timeout, "R6 clean read after failure",
          {fail_ecc, fail_timeout}, 0);
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0, "R8 idle after read",
          {cs_n, sclk, busy}, 3'b100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule